// File: doc/BRIEF.md
# Sample-Convert-Transfer Acquisition Sequencer

This block runs the sampling periods of a multichannel acquisition front end. At the start of each period it commands every sample-and-hold channel to track at once. When the hold begins, it walks a host-loaded scan list. For each entry it steers the analog multiplexer to that channel, pulses the converter's start line and watches the converter status line. On the falling edge of the status line it captures the 12-bit result, tags it with the channel number and raises a DMA request. A programmable idle delay ends the period, and then the next period begins.

All timing is counted in ticks of an internal divided clock. A period lasts SAMPLE_TICKS + N·SLOT_TICKS + D ticks, where N is the number of scan entries and D is the value of the delay register. A DMA request may stay pending into the following conversion slot, so transfers overlap conversions. Host lines start, stop and re-initialise the unit. A sticky error flag records a conversion that never completes and a result that arrives while the previous one is still unacknowledged.

Top module: `acq_sequencer`

## Requirements
- R1: After reset, and in the clock after initCmd, running, sampleHold, convStart, dmaReq and convErr are all 0.
- R2: After a startCmd pulse, running is 1 in the next clock. Within CLK_DIV+2 clocks, sampleHold rises and then stays high for exactly SAMPLE_TICKS·CLK_DIV clocks.
- R3: After the hold, one slot of SLOT_TICKS·CLK_DIV clocks follows per scan entry, in entry order from entry 0. muxAddr holds the entry's channel for the whole slot. The scan ends at the first entry whose last flag is set, and at entry 15 regardless of its flag.
- R4: convStart is high only in clocks CLK_DIV/2 to CLK_DIV-1 of each slot, which is the second phase of the slot's first tick.
- R5: A high-to-low edge of adcStatus within a slot captures dmaWord = {channel in bits 15:12, adcData in bits 11:0}. dmaReq is high in the next clock and stays high until dmaAck is sampled high; it is low in the clock after that.
- R6: A pending DMA request does not stall the sequence; the next slot starts on schedule with dmaReq still high.
- R7: After the last slot there are D ticks with no command, where D is the delay register (0 means none). The period is (SAMPLE_TICKS + N·SLOT_TICKS + D)·CLK_DIV clocks.
- R8: After stopCmd, running is 0 in the next clock, the current period completes, and no further sampleHold follows.
- R9: If no falling edge of adcStatus has been seen by the end of a slot, convErr is set and stays set.
- R10: If a result is captured while dmaReq is high and dmaAck is low, convErr is set.
- R11: errClr clears convErr when no new error occurs in the same clock. initCmd clears convErr and dmaReq and returns the unit to idle.
- R12: listWe writes listData into scan entry listAddr. Bit 4 of listData is the last flag and bits 3:0 are the channel. delayWe loads delayData into the delay register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initCmd | input | 1 | Host initialise: return to idle, clear flags |
| startCmd | input | 1 | Host start of acquisition |
| stopCmd | input | 1 | Host stop at end of current period |
| errClr | input | 1 | Clear the error flag |
| listWe | input | 1 | Scan-list write strobe |
| listAddr | input | 4 | Scan-list entry index |
| listData | input | 5 | {last flag, channel} |
| delayWe | input | 1 | Delay-register write strobe |
| delayData | input | 16 | Delay in ticks |
| adcStatus | input | 1 | Converter busy, falls when result valid |
| adcData | input | 12 | Converter result, two's complement |
| dmaAck | input | 1 | DMA cycle acknowledge |
| sampleHold | output | 1 | Simultaneous sample command to all channels |
| muxAddr | output | 4 | Multiplexer channel address |
| convStart | output | 1 | Start-convert pulse |
| dmaWord | output | 16 | Captured word {channel, result} |
| dmaReq | output | 1 | DMA cycle request |
| running | output | 1 | Acquisition active indicator |
| convErr | output | 1 | Sticky conversion error flag |

## Verification
A slot or tick counter that is off by one shifts every later sampleHold edge, convStart pulse and muxAddr change. The per-clock reference comparison catches this in the first period, at the first mistimed boundary. A scan pointer that wraps or stops wrongly shows as a wrong muxAddr value at the start of the offending slot. Wrong capture or request handling shows either as a mismatched dmaWord at the next request edge or as convErr rising in a run where it should stay low.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_SLOT   = 2'd2,
    ST_DELAY  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic slotFirst;  // hold ends, first slot begins
    logic slotNext;   // slot ends and another slot follows
    logic slotEnd;    // any slot ends
    logic inSlot;     // a conversion slot is active
  } seqStrobe_t;
endpackage

// File: rtl/acq_tick.sv
module acq_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  output logic tick,
  output logic phase2
);
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLK_DIV / 2);

  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign tick   = (divCnt == DIV_LAST);
  // control bits settle in the first half; commands use the second
  assign phase2 = (divCnt >= DIV_HALF);
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int SAMPLE_TICKS = 8,
  parameter int SLOT_TICKS   = 11,
  parameter int DELAY_W      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               phase2,
  input  logic               initCmd,
  input  logic               startCmd,
  input  logic               stopCmd,
  input  logic               curLast,
  input  logic [DELAY_W-1:0] delayVal,
  output seqStrobe_t         strobe,
  output logic               running,
  output logic               sampleHold,
  output logic               convStart
);
  localparam int CNT_MAX = (SAMPLE_TICKS > SLOT_TICKS) ? SAMPLE_TICKS : SLOT_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_TICKS - 1);
  localparam logic [CNT_W-1:0] SLOT_LAST   = CNT_W'(SLOT_TICKS - 1);

  seqState_t          state;
  logic [CNT_W-1:0]   tickCnt;
  logic [DELAY_W-1:0] dlyCnt;
  logic               sampleDone;
  logic               slotDone;

  assign sampleDone = (state == ST_SAMPLE) && tick && (tickCnt == SAMPLE_LAST);
  assign slotDone   = (state == ST_SLOT) && tick && (tickCnt == SLOT_LAST);

  assign strobe.slotFirst = sampleDone;
  assign strobe.slotEnd   = slotDone;
  assign strobe.slotNext  = slotDone && !curLast;
  assign strobe.inSlot    = (state == ST_SLOT);

  assign sampleHold = (state == ST_SAMPLE);
  assign convStart  = (state == ST_SLOT) && (tickCnt == '0) && phase2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      dlyCnt  <= '0;
      running <= 1'b0;
    end else if (initCmd) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      dlyCnt  <= '0;
      running <= 1'b0;
    end else begin
      if (stopCmd) running <= 1'b0;
      else if (startCmd) running <= 1'b1;

      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (running) begin
              state   <= ST_SAMPLE;
              tickCnt <= '0;
            end
          end
          ST_SAMPLE: begin
            if (tickCnt == SAMPLE_LAST) begin
              state   <= ST_SLOT;
              tickCnt <= '0;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_SLOT: begin
            if (tickCnt == SLOT_LAST) begin
              tickCnt <= '0;
              if (curLast) begin
                if (delayVal == '0) begin
                  state <= running ? ST_SAMPLE : ST_IDLE;
                end else begin
                  state  <= ST_DELAY;
                  dlyCnt <= delayVal;
                end
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_DELAY: begin
            if (dlyCnt <= DELAY_W'(1)) state <= running ? ST_SAMPLE : ST_IDLE;
            else dlyCnt <= dlyCnt - 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int CH_W    = 4,
  parameter int DATA_W  = 12,
  parameter int DELAY_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 initCmd,
  input  logic                 errClr,
  input  logic                 listWe,
  input  logic [CH_W-1:0]      listAddr,
  input  logic [CH_W:0]        listData,
  input  logic                 delayWe,
  input  logic [DELAY_W-1:0]   delayData,
  input  logic                 adcStatus,
  input  logic [DATA_W-1:0]    adcData,
  input  logic                 dmaAck,
  input  seqStrobe_t           strobe,
  output logic [CH_W-1:0]      muxAddr,
  output logic                 curLast,
  output logic [DELAY_W-1:0]   delayVal,
  output logic [CH_W+DATA_W-1:0] dmaWord,
  output logic                 dmaReq,
  output logic                 convErr
);
  localparam int DEPTH = 1 << CH_W;

  logic [CH_W:0]   listMem [DEPTH];
  logic [CH_W-1:0] ptr;
  logic [CH_W-1:0] ptrNext;
  logic            statusQ;
  logic            captured;
  logic            fallSeen;
  logic            slotTimeout;
  logic            overrun;

  assign ptrNext     = ptr + 1'b1;
  // the last list entry always closes the scan
  assign curLast     = listMem[ptr][CH_W] | (&ptr);
  assign fallSeen    = statusQ & ~adcStatus & strobe.inSlot & ~captured;
  assign slotTimeout = strobe.slotEnd & ~captured & ~fallSeen;
  assign overrun     = fallSeen & dmaReq & ~dmaAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) listMem[i] <= '0;
    end else if (listWe) begin
      listMem[listAddr] <= listData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) delayVal <= '0;
    else if (delayWe) delayVal <= delayData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= 1'b0;
      ptr      <= '0;
      muxAddr  <= '0;
      captured <= 1'b0;
      dmaWord  <= '0;
      dmaReq   <= 1'b0;
      convErr  <= 1'b0;
    end else begin
      statusQ <= adcStatus;

      if (strobe.slotFirst) begin
        ptr     <= '0;
        muxAddr <= listMem[0][CH_W-1:0];
      end else if (strobe.slotNext) begin
        ptr     <= ptrNext;
        muxAddr <= listMem[ptrNext][CH_W-1:0];
      end

      if (strobe.slotFirst || strobe.slotEnd) captured <= 1'b0;
      else if (fallSeen) captured <= 1'b1;

      if (fallSeen) dmaWord <= {muxAddr, adcData};

      if (initCmd) begin
        dmaReq  <= 1'b0;
        convErr <= 1'b0;
      end else begin
        if (fallSeen) dmaReq <= 1'b1;
        else if (dmaAck) dmaReq <= 1'b0;

        if (slotTimeout || overrun) convErr <= 1'b1;
        else if (errClr) convErr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int SAMPLE_TICKS = 8,
  parameter int SLOT_TICKS   = 11,
  parameter int DELAY_W      = 16,
  parameter int CH_W         = 4,
  parameter int DATA_W       = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   initCmd,
  input  logic                   startCmd,
  input  logic                   stopCmd,
  input  logic                   errClr,
  input  logic                   listWe,
  input  logic [CH_W-1:0]        listAddr,
  input  logic [CH_W:0]          listData,
  input  logic                   delayWe,
  input  logic [DELAY_W-1:0]     delayData,
  input  logic                   adcStatus,
  input  logic [DATA_W-1:0]      adcData,
  input  logic                   dmaAck,
  output logic                   sampleHold,
  output logic [CH_W-1:0]        muxAddr,
  output logic                   convStart,
  output logic [CH_W+DATA_W-1:0] dmaWord,
  output logic                   dmaReq,
  output logic                   running,
  output logic                   convErr
);
  logic               tick;
  logic               phase2;
  logic               curLast;
  logic [DELAY_W-1:0] delayVal;
  seqStrobe_t         strobe;

  acq_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rstN(rstN), .tick(tick), .phase2(phase2)
  );

  acq_ctrl #(
    .SAMPLE_TICKS(SAMPLE_TICKS), .SLOT_TICKS(SLOT_TICKS), .DELAY_W(DELAY_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .phase2(phase2),
    .initCmd(initCmd), .startCmd(startCmd), .stopCmd(stopCmd),
    .curLast(curLast), .delayVal(delayVal), .strobe(strobe),
    .running(running), .sampleHold(sampleHold), .convStart(convStart)
  );

  acq_datapath #(
    .CH_W(CH_W), .DATA_W(DATA_W), .DELAY_W(DELAY_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .initCmd(initCmd), .errClr(errClr),
    .listWe(listWe), .listAddr(listAddr), .listData(listData),
    .delayWe(delayWe), .delayData(delayData),
    .adcStatus(adcStatus), .adcData(adcData), .dmaAck(dmaAck),
    .strobe(strobe), .muxAddr(muxAddr), .curLast(curLast),
    .delayVal(delayVal), .dmaWord(dmaWord), .dmaReq(dmaReq),
    .convErr(convErr)
  );
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int CH_W   = 4,
  parameter int DATA_W = 12
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   initCmd,
  input logic                   errClr,
  input logic                   dmaAck,
  input logic                   sampleHold,
  input logic [CH_W-1:0]        muxAddr,
  input logic                   convStart,
  input logic [CH_W+DATA_W-1:0] dmaWord,
  input logic                   dmaReq,
  input logic                   running,
  input logic                   convErr
);
  // R4: a start pulse never coincides with the sample command
  a_r4_start_outside_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleHold && convStart));

  // R4: the multiplexer address is steady around a start pulse
  a_r4_mux_steady: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> $stable(muxAddr));

  // R5: a request stays up until acknowledged
  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && !dmaAck && !initCmd |=> dmaReq);

  // R5: the pending word is held unless an overrun is flagged
  a_r5_word_held: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && !dmaAck && !initCmd |=> $stable(dmaWord) || convErr);

  // R8: a new period only begins while acquisition was running
  a_r8_hold_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleHold) |-> $past(running));

  // R9: the error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    convErr && !errClr && !initCmd |=> convErr);

  // R11: initialise quiets every status output
  a_r11_init_clears: assert property (@(posedge clk) disable iff (!rstN)
    initCmd |=> !convErr && !dmaReq && !running && !sampleHold);
endmodule

bind acq_sequencer acq_sequencer_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int A = 8;
  localparam int B = 11;
  localparam int CONV_LAT = 20;
  localparam int ACK_DLY = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initCmd = 0, startCmd = 0, stopCmd = 0, errClr = 0;
  logic listWe = 0;
  logic [3:0] listAddr = '0;
  logic [4:0] listData = '0;
  logic delayWe = 0;
  logic [15:0] delayData = '0;
  logic adcStatus = 0;
  logic [11:0] adcData = '0;
  logic dmaAck = 0;
  logic sampleHold, convStart, dmaReq, running, convErr;
  logic [3:0] muxAddr;
  logic [15:0] dmaWord;

  acq_sequencer #(
    .CLK_DIV(DIV), .SAMPLE_TICKS(A), .SLOT_TICKS(B),
    .DELAY_W(16), .CH_W(4), .DATA_W(12)
  ) u_acq_sequencer (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vecCount = 0;
  int missCount = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      missCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  endtask

  // ---------------- reference model state ----------------
  int listCh [16];
  int nEntries = 1;
  int delayTicks = 0;
  bit armed = 0, synced = 0, stopped = 0, runExp = 0;
  int pos = 0, armWait = 0, periods = 0, overlapSeen = 0;

  always @(negedge clk) begin
    if (rstN && !done) begin
      int hA, sl, P, k, o;
      bit sh, cs;
      hA = A * DIV;
      sl = B * DIV;
      P  = (A + nEntries * B + delayTicks) * DIV;
      if (armed && !synced) begin
        if (sampleHold) begin
          synced = 1;
          pos = 0;
        end else begin
          armWait++;
          if (armWait > DIV + 2) begin
            chk("R2 hold start", 0, 1);
            armed = 0;
          end
        end
      end
      if (synced) begin
        if (pos < hA) begin
          chk("R2 hold", sampleHold, 1);
          chk("R4 no start in hold", convStart, 0);
        end else if (pos < hA + nEntries * sl) begin
          k = (pos - hA) / sl;
          o = (pos - hA) % sl;
          cs = (o >= DIV / 2) && (o < DIV);
          chk("R3 hold low in slot", sampleHold, 0);
          chk("R4 start pulse", convStart, cs);
          chk("R3 mux address", muxAddr, listCh[k]);
          if (o == 0 && k > 0 && dmaReq) overlapSeen++;
        end else begin
          chk("R7 delay hold", sampleHold, 0);
          chk("R7 delay start", convStart, 0);
        end
        pos++;
        if (pos == P) begin
          pos = 0;
          periods++;
          if (stopped) begin
            synced = 0;
            armed = 0;
          end
        end
      end else if (!armed) begin
        sh = 0;
        chk("R8 idle hold", sampleHold, sh);
        chk("R8 idle start", convStart, 0);
      end
      chk("R2 running", running, runExp);
    end
  end

  // ---------------- converter model ----------------
  bit hang = 0;
  bit adcClear = 0;
  bit adcBusy = 0;
  int lat = 0;
  int convSeq = 0;
  logic [15:0] expQ [$];

  always @(negedge clk) begin
    if (adcClear) begin
      adcClear = 0;
      adcBusy = 0;
      adcStatus = 0;
    end else if (rstN) begin
      if (convStart && !adcBusy) begin
        logic [11:0] d;
        d = 12'((int'(muxAddr) * 211 + convSeq * 7) & 12'hfff);
        convSeq++;
        adcBusy = 1;
        adcStatus = 1;
        adcData = d;
        lat = CONV_LAT;
        if (!hang) expQ.push_back({muxAddr, d});
      end else if (adcBusy && !hang) begin
        lat--;
        if (lat == 0) begin
          adcStatus = 0;
          adcBusy = 0;
        end
      end
    end
  end

  // ---------------- DMA model and word check ----------------
  bit ackEnable = 1;
  bit checkWords = 1;
  bit reqPrev = 0;
  bit ackedLast = 0;
  int ackCnt = 0;

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (ackedLast) begin
        chk("R5 release after ack", dmaReq, 0);
        ackedLast = 0;
      end
      if (dmaReq && !reqPrev && checkWords) begin
        if (expQ.size() > 0) chk("R5 captured word", dmaWord, expQ.pop_front());
        else chk("R5 unexpected request", 1, 0);
      end
      if (dmaReq && ackEnable) begin
        ackCnt++;
        if (ackCnt == ACK_DLY) begin
          dmaAck = 1;
          ackedLast = 1;
        end else dmaAck = 0;
      end else begin
        dmaAck = 0;
        ackCnt = 0;
      end
      reqPrev = dmaReq;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      missCount++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      finishRun();
    end
  end

  // ---------------- host tasks ----------------
  task automatic writeEntry(input int idx, input int ch, input bit last);
    // R12: bit 4 is the last flag, bits 3:0 the channel
    @(posedge clk); #1;
    listWe = 1; listAddr = 4'(idx); listData = {last, 4'(ch)};
    @(posedge clk); #1;
    listWe = 0;
    listCh[idx] = ch;
  endtask

  task automatic writeDelay(input int d);
    @(posedge clk); #1;
    delayWe = 1; delayData = 16'(d);
    @(posedge clk); #1;
    delayWe = 0;
    delayTicks = d;
  endtask

  task automatic doStart();
    @(posedge clk); #1;
    startCmd = 1;
    @(posedge clk); #1;
    startCmd = 0;
    runExp = 1; stopped = 0; armWait = 0; armed = 1;
  endtask

  task automatic doStop();
    @(posedge clk); #1;
    stopCmd = 1;
    @(posedge clk); #1;
    stopCmd = 0;
    runExp = 0; stopped = 1;
  endtask

  task automatic waitPeriods(input int n);
    int p0;
    p0 = periods;
    wait (periods >= p0 + n);
  endtask

  task automatic stopAndSettle();
    doStop();
    wait (!synced);
    repeat (3 * DIV) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 running", running, 0);
    chk("R1 sampleHold", sampleHold, 0);
    chk("R1 convStart", convStart, 0);
    chk("R1 dmaReq", dmaReq, 0);
    chk("R1 convErr", convErr, 0);

    // scan of five entries out of order, delay 5 (R3, R6, R7, R12)
    writeEntry(0, 3, 0);
    writeEntry(1, 0, 0);
    writeEntry(2, 9, 0);
    writeEntry(3, 15, 0);
    writeEntry(4, 6, 1);
    nEntries = 5;
    writeDelay(5);
    doStart();
    waitPeriods(3);
    stopAndSettle();
    chk("R6 transfer overlaps next slot", int'(overlapSeen > 0), 1);
    chk("R9 no error in clean run", convErr, 0);
    chk("R5 no request left", dmaReq, 0);

    // full list without last flags wraps at entry 15, delay 0 (R3, R7)
    for (int i = 0; i < 16; i++) writeEntry(i, (i * 7 + 5) % 16, 0);
    nEntries = 16;
    writeDelay(0);
    doStart();
    waitPeriods(2);
    stopAndSettle();
    chk("R10 no overrun in clean run", convErr, 0);

    // converter never finishes (R9, R11)
    writeEntry(0, 7, 1);
    nEntries = 1;
    writeDelay(2);
    hang = 1; checkWords = 0;
    doStart();
    waitPeriods(1);
    @(negedge clk);
    chk("R9 timeout sets error", convErr, 1);
    stopAndSettle();
    chk("R9 error stays set", convErr, 1);
    @(posedge clk); #1 errClr = 1;
    @(posedge clk); #1 errClr = 0;
    @(negedge clk);
    chk("R11 clear drops error", convErr, 0);
    hang = 0; adcClear = 1;
    repeat (2) @(negedge clk);
    expQ.delete();
    checkWords = 1;

    // no acknowledge, second result overruns (R10, R5)
    writeEntry(0, 2, 0);
    writeEntry(1, 11, 1);
    nEntries = 2;
    writeDelay(0);
    ackEnable = 0; checkWords = 0;
    doStart();
    waitPeriods(1);
    @(negedge clk);
    chk("R10 overrun sets error", convErr, 1);
    chk("R5 request held without ack", dmaReq, 1);
    stopAndSettle();
    ackEnable = 1;
    repeat (ACK_DLY + 4) @(negedge clk);
    chk("R5 request dropped after ack", dmaReq, 0);
    expQ.delete();

    // initialise clears the flags (R1, R11)
    @(posedge clk); #1 initCmd = 1;
    @(posedge clk); #1 initCmd = 0;
    @(negedge clk);
    chk("R11 init clears error", convErr, 0);
    chk("R1 init running", running, 0);
    chk("R1 init dmaReq", dmaReq, 0);
    chk("R1 init sampleHold", sampleHold, 0);
    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule